// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital control of a successive-approximation analog-to-digital converter. It derives a conversion tick from the system clock by a power-of-two divisor and counts conversion cycles. It marks the sample instant, drives a trial code to an external DAC and reads back a single comparator bit. From these it settles one result bit per tick, most significant bit first. The analog path (input multiplexer, gain, DAC and comparator) sits outside the block.

Software starts a conversion with a start pulse. The busy bit then stays high until the result lands, and the result lands together with a one-cycle done strobe and a sticky completion flag. In free-running mode the sequencer restarts by itself after each result. A channel or reference selection is copied to the active outputs only while the sequencer is idle or at the moment a result lands, so a conversion in flight never sees a change. The first conversion after enable uses a longer schedule so the analog side can settle. Dropping enable aborts any conversion and re-arms that longer schedule.

Top module: `sar_seq`

## Requirements
- R1: The comparator input is 1 when the analog input is at or above `dac_code`. Under that rule the sequencer resolves the result MSB first, one bit per tick, and `result` equals the input code.
- R2: With `clk_sel` = s, one conversion tick lasts D = 2^max(s,1) system clocks (s=0 and s=1 both give 2). The divider restarts from zero whenever `en` is low.
- R3: The first conversion after `en` rises lasts 25 ticks and its sample strobe is at tick 14. When `en` and `start` are first presented together, `sample` is seen after 14·D rising edges and `done` after 25·D.
- R4: Every later conversion lasts 13 ticks with its sample strobe at tick 2. If a start is presented in the cycle right after a `done`, `sample` follows after 2·D edges and `done` after 13·D edges.
- R5: `busy` is 0 after reset and rises in the cycle after an accepted start. In single mode `busy` falls in the same cycle that `done` and `flag` rise.
- R6: With `free_run` high, a new conversion begins on the tick after each result without software action. `busy` stays high, consecutive `done` strobes are 13·D cycles apart, and this holds whether or not `flag` is cleared.
- R7: `act_ch`/`act_ref` follow `sel_ch`/`sel_ref` only while `en` is high and the sequencer is idle, or in the cycle a result lands. A change made during a conversion appears in the same cycle as its `done`. A change made while `en` is low has no effect.
- R8: `flag` is set at each result and cleared by a `flag_clr` or `irq_ack` pulse; a set in the same cycle takes precedence. `irq` is `flag` AND `irq_en`.
- R9: `en` low clears `busy` on the next cycle, aborts the conversion without a `done`, and makes the next conversion a 25-tick one. A `start` while `en` is low is ignored.
- R10: `sample` and `done` are single-cycle strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Converter enable |
| clk_sel | input | 3 | Tick divisor select |
| start | input | 1 | Start request pulse |
| free_run | input | 1 | Restart automatically after each result |
| sel_ch | input | 3 | Requested channel |
| sel_ref | input | 2 | Requested reference |
| flag_clr | input | 1 | Clear completion flag |
| irq_ack | input | 1 | Interrupt acknowledge, also clears the flag |
| irq_en | input | 1 | Interrupt enable |
| cmp | input | 1 | Comparator: 1 when input is at or above the DAC code |
| dac_code | output | 10 | Trial code for the DAC |
| sample | output | 1 | Sample-and-hold strobe |
| act_ch | output | 3 | Channel in effect |
| act_ref | output | 2 | Reference in effect |
| result | output | 10 | Last conversion result |
| done | output | 1 | Result strobe |
| busy | output | 1 | Start bit / conversion in progress |
| flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block at its default parameters: 10 result bits, a 7-bit divider and a 3-bit select. At these values all 1024 input codes can be swept in free-running mode at divide-by-2, and all eight divisor selections can each be timed over a full first conversion. The exact cycle counts of the first and normal schedules follow from the divisor arithmetic. The deferral of selections, the abort path and the flag and interrupt gating are driven on the same small configuration.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
   parameter int PRE_W = 7,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int NSEL = 1 << SEL_W;

   logic [PRE_W-1:0] cnt;
   logic [NSEL-1:0]  hit;

   if (PRE_W < NSEL - 1) begin : g_chk_width
      $error("sar_prescaler: PRE_W too small for the select range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!en)    cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end

   for (genvar g = 0; g < NSEL; g++) begin : g_tap
      localparam int LG = (g == 0) ? 1 : ((g > PRE_W) ? PRE_W : g);
      assign hit[g] = &cnt[LG-1:0];
   end

   assign tick = en & hit[sel];

   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/sar_search.sv
module sar_search #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic             step,
   input  logic             cmp,
   output logic [RES_W-1:0] code,
   output logic [RES_W-1:0] decided
);
   logic [RES_W-1:0] ptr;
   logic [RES_W-1:0] nxt;

   if (RES_W < 2) begin : g_chk_res
      $error("sar_search: RES_W must be at least 2");
   end

   for (genvar b = 0; b < RES_W; b++) begin : g_bit
      assign decided[b] = code[b] & (ptr[b] ? cmp : 1'b1);
      if (b == 0) begin : g_lsb
         assign nxt[b] = decided[b];
      end else begin : g_upper
         assign nxt[b - 1 + 1] = decided[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
         ptr  <= '0;
      end else if (clr) begin
         code <= '0;
         ptr  <= '0;
      end else if (load) begin
         code <= {1'b1, {(RES_W-1){1'b0}}};
         ptr  <= {1'b1, {(RES_W-1){1'b0}}};
      end else if (step) begin
         code <= nxt | (ptr >> 1);
         ptr  <= ptr >> 1;
      end
   end

   assert_ptr_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ptr));
   assert_step_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !load) |-> (ptr != '0));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
   import sar_seq_pkg::*;
#(
   parameter int RES_W        = 10,
   parameter int PRE_W        = 7,
   parameter int SEL_W        = 3,
   parameter int CH_W         = 3,
   parameter int REF_W        = 2,
   parameter int SAMPLE_NORM  = 2,
   parameter int SAMPLE_FIRST = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] clk_sel,
   input  logic             start,
   input  logic             free_run,
   input  logic [CH_W-1:0]  sel_ch,
   input  logic [REF_W-1:0] sel_ref,
   input  logic             flag_clr,
   input  logic             irq_ack,
   input  logic             irq_en,
   input  logic             cmp,
   output logic [RES_W-1:0] dac_code,
   output logic             sample,
   output logic [CH_W-1:0]  act_ch,
   output logic [REF_W-1:0] act_ref,
   output logic [RES_W-1:0] result,
   output logic             done,
   output logic             busy,
   output logic             flag,
   output logic             irq
);
   localparam int LEN_NORM  = SAMPLE_NORM + RES_W + 1;
   localparam int LEN_FIRST = SAMPLE_FIRST + RES_W + 1;
   localparam int CNT_W     = $clog2(LEN_FIRST + 1);

   localparam logic [CNT_W-1:0] SN_SAMP = CNT_W'(SAMPLE_NORM);
   localparam logic [CNT_W-1:0] SN_LOAD = CNT_W'(SAMPLE_NORM + 1);
   localparam logic [CNT_W-1:0] SN_STEP = CNT_W'(SAMPLE_NORM + 2);
   localparam logic [CNT_W-1:0] SN_LEN  = CNT_W'(LEN_NORM);
   localparam logic [CNT_W-1:0] SF_SAMP = CNT_W'(SAMPLE_FIRST);
   localparam logic [CNT_W-1:0] SF_LOAD = CNT_W'(SAMPLE_FIRST + 1);
   localparam logic [CNT_W-1:0] SF_STEP = CNT_W'(SAMPLE_FIRST + 2);
   localparam logic [CNT_W-1:0] SF_LEN  = CNT_W'(LEN_FIRST);

   if (SAMPLE_NORM < 1 || SAMPLE_FIRST < SAMPLE_NORM) begin : g_chk_sched
      $error("sar_seq: sample points must satisfy 1 <= SAMPLE_NORM <= SAMPLE_FIRST");
   end

   seq_state_t       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] k;
   logic             first_pend;
   logic             first_cur;
   logic             tick;
   logic             run_tick;
   logic [CNT_W-1:0] at_samp, at_load, at_step, at_len;
   logic             sar_load, sar_step, complete;
   logic [RES_W-1:0] decided;

   sar_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) i_div (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .sel  (clk_sel),
      .tick (tick)
   );

   always_comb begin
      at_samp = first_cur ? SF_SAMP : SN_SAMP;
      at_load = first_cur ? SF_LOAD : SN_LOAD;
      at_step = first_cur ? SF_STEP : SN_STEP;
      at_len  = first_cur ? SF_LEN  : SN_LEN;
      k        = cnt + 1'b1;
      run_tick = (state == SEQ_RUN) && tick;
      sar_load = run_tick && (k == at_load);
      sar_step = run_tick && (k >= at_step) && (k <= at_len);
      complete = run_tick && (k == at_len);
   end

   sar_search #(.RES_W(RES_W)) i_sar (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!en),
      .load   (sar_load),
      .step   (sar_step),
      .cmp    (cmp),
      .code   (dac_code),
      .decided(decided)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SEQ_IDLE;
         cnt        <= '0;
         first_pend <= 1'b1;
         first_cur  <= 1'b0;
      end else if (!en) begin
         state      <= SEQ_IDLE;
         cnt        <= '0;
         first_pend <= 1'b1;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state     <= SEQ_RUN;
                  cnt       <= '0;
                  first_cur <= first_pend;
               end
            end
            SEQ_RUN: begin
               if (complete) begin
                  first_pend <= 1'b0;
                  cnt        <= '0;
                  if (free_run) first_cur <= 1'b0;
                  else          state     <= SEQ_IDLE;
               end else if (tick) begin
                  cnt <= k;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done    <= 1'b0;
         sample  <= 1'b0;
         result  <= '0;
         flag    <= 1'b0;
         act_ch  <= '0;
         act_ref <= '0;
      end else begin
         done   <= complete;
         sample <= run_tick && (k == at_samp);
         if (complete) result <= decided;
         if (complete)                 flag <= 1'b1;
         else if (flag_clr || irq_ack) flag <= 1'b0;
         if (en && (state == SEQ_IDLE || complete)) begin
            act_ch  <= sel_ch;
            act_ref <= sel_ref;
         end
      end
   end

   assign busy = (state == SEQ_RUN);
   assign irq  = flag & irq_en;

   assert_single_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy == $past(free_run)));
   assert_flag_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> flag);
   assert_clear_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flag_clr) && !done) |-> !flag);
   assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);
   assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && !done) |-> ($stable(act_ch) && $stable(act_ref)));
   assert_sample_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sample |=> !sample);
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_sample_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && en) |-> busy);
endmodule

// File: tb/test_sar_seq.sv
module test_sar_seq;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       en, start, free_run, flag_clr, irq_ack, irq_en;
   logic [2:0] clk_sel, sel_ch;
   logic [1:0] sel_ref;
   logic       cmp;
   logic [9:0] dac_code, result;
   logic       sample, done, busy, flag, irq;
   logic [2:0] act_ch;
   logic [1:0] act_ref;
   logic [9:0] vin;

   int n_checks = 0;
   int n_err    = 0;

   always #2.5 clk = ~clk;

   assign cmp = (vin >= dac_code);

   sar_seq i_sar_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .clk_sel(clk_sel), .start(start),
      .free_run(free_run), .sel_ch(sel_ch), .sel_ref(sel_ref),
      .flag_clr(flag_clr), .irq_ack(irq_ack), .irq_en(irq_en), .cmp(cmp),
      .dac_code(dac_code), .sample(sample), .act_ch(act_ch), .act_ref(act_ref),
      .result(result), .done(done), .busy(busy), .flag(flag), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int div_of(input int s);
      return 1 << ((s == 0) ? 1 : s);
   endfunction

   // Counts rising edges until done is seen; records the edge of the first sample.
   task automatic wait_done(output int nd, output int ns);
      nd = 0;
      ns = -1;
      while (nd < 5000) begin
         @(posedge clk);
         nd++;
         @(negedge clk);
         start = 1'b0;
         if (sample && ns < 0) ns = nd;
         if (done) break;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      int nd, ns;
      rst_n = 1'b0; en = 1'b0; start = 1'b0; free_run = 1'b0; flag_clr = 1'b0;
      irq_ack = 1'b0; irq_en = 1'b0; clk_sel = 3'd0; sel_ch = 3'd0; sel_ref = 2'd0;
      vin = 10'd0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !flag && !irq && !sample, "R5 reset", int'(busy), 0);
      chk(result == 10'd0, "R5 reset result", int'(result), 0);

      // R2/R3/R1: every divisor select, first conversion after enable
      for (int s = 0; s < 8; s++) begin
         en = 1'b0; clk_sel = 3'(s);
         repeat (2) @(negedge clk);
         vin = 10'((s * 131 + 7) % 1024);
         en = 1'b1; start = 1'b1;
         wait_done(nd, ns);
         chk(nd == 25 * div_of(s), "R2 R3 first done edge", nd, 25 * div_of(s));
         chk(ns == 14 * div_of(s), "R3 first sample edge", ns, 14 * div_of(s));
         chk(result == vin, "R1 result", int'(result), int'(vin));
         chk(!busy && flag, "R5 busy clears with flag", int'(busy), 0);
         flag_clr = 1'b1;
         @(negedge clk);
         flag_clr = 1'b0;
         chk(!flag, "R8 flag_clr", int'(flag), 0);
      end

      // R4: back-to-back normal conversions, divide by 4
      clk_sel = 3'd2; vin = 10'd513;
      start = 1'b1;
      wait_done(nd, ns);
      vin = 10'd300; start = 1'b1;
      wait_done(nd, ns);
      chk(nd == 13 * 4, "R4 normal done edge", nd, 52);
      chk(ns == 2 * 4, "R4 normal sample edge", ns, 8);
      chk(result == 10'd300, "R1 result normal", int'(result), 300);
      @(negedge clk);
      chk(!done, "R10 done single cycle", int'(done), 0);

      // R7: selection deferral
      clk_sel = 3'd1; sel_ch = 3'd3; sel_ref = 2'd1;
      @(negedge clk);
      chk(act_ch == 3'd3 && act_ref == 2'd1, "R7 idle update", int'(act_ch), 3);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      sel_ch = 3'd6; sel_ref = 2'd2;
      repeat (3) @(negedge clk);
      chk(busy && act_ch == 3'd3 && act_ref == 2'd1, "R7 held during conversion", int'(act_ch), 3);
      wait_done(nd, ns);
      chk(act_ch == 3'd6 && act_ref == 2'd2, "R7 update at done", int'(act_ch), 6);

      // R8: interrupt gating and acknowledge
      chk(flag && !irq, "R8 irq masked", int'(irq), 0);
      irq_en = 1'b1;
      @(negedge clk);
      chk(irq, "R8 irq enabled", int'(irq), 1);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      chk(!flag && !irq, "R8 irq_ack clears", int'(flag), 0);

      // R7/R9: enable low ignores selection and start
      en = 1'b0; sel_ch = 3'd1; start = 1'b1;
      repeat (3) @(negedge clk);
      start = 1'b0;
      chk(act_ch == 3'd6, "R7 ignored while disabled", int'(act_ch), 6);
      chk(!busy, "R9 start ignored while disabled", int'(busy), 0);

      // R9: abort mid-conversion
      en = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk(!busy, "R9 abort clears busy", int'(busy), 0);
      nd = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (done) nd++;
      end
      chk(nd == 0, "R9 no done after abort", nd, 0);
      vin = 10'd77; en = 1'b1; start = 1'b1;
      wait_done(nd, ns);
      chk(nd == 25 * 2, "R9 long schedule after abort", nd, 50);
      chk(result == 10'd77, "R1 result after abort", int'(result), 77);

      // R6/R1: free-running sweep of all codes, flag never cleared
      irq_en = 1'b0; clk_sel = 3'd0; free_run = 1'b1; vin = 10'd0; start = 1'b1;
      wait_done(nd, ns);
      chk(result == 10'd0, "R1 sweep code 0", int'(result), 0);
      for (int v = 1; v < 1024; v++) begin
         vin = 10'(v);
         wait_done(nd, ns);
         chk(nd == 26, "R6 free-run period", nd, 26);
         chk(result == 10'(v), "R1 sweep result", int'(result), v);
         chk(busy && flag, "R6 busy stays high", int'(busy), 1);
      end
      free_run = 1'b0;
      wait_done(nd, ns);
      chk(!busy, "R5 single mode stops", int'(busy), 0);

      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule